// File: doc/BRIEF.md
# Preamble Pattern Run Detector

This block searches a sampled read-data pulse stream for a preamble. A preamble is an unbroken run of pulses that all have the same spacing. The data-synchronous clock samples `pulse_in` once per bit cell. The 2-bit select `pat_sel` picks the spacing: 1, 2, 3 or 4 bit cells. The search starts only when the read gate is high and the zero-phase-start sequence has reported completion. The block counts good intervals. When the run reaches the length required for the selected spacing, it raises `pre_det`. The flag stays high until the read gate drops.

The control is one state machine with four states:
- IDLE: not searching.
- ARMED: waiting for a reference pulse.
- TRACK: counting good intervals.
- LOCKED: flag latched.

The transitions are:
- ARM (IDLE to ARMED): the read gate is high and the done strobe arrives.
- REFER (ARMED to TRACK): the first pulse arrives.
- GOOD (TRACK stays in TRACK): the interval is right, so the run count goes up by one.
- SLIP (TRACK stays in TRACK): the interval is short. The count is cleared and the pulse becomes the new reference.
- LOST (TRACK to ARMED): an expected pulse is missing, or the select changes.
- LOCK (TRACK to LOCKED): the run reaches its target.
- DROP (any state to IDLE): the read gate is low.

Top module: `ppd_run_detector`

## Requirements
- R1: After reset, `pre_det` is 0.
- R2: Pulses are ignored until a `zps_done` strobe is sampled while `rd_gate` is 1. A `zps_done` strobe sampled while `rd_gate` is 0 does not arm the search.
- R3: `pat_sel` value k (0 to 3) selects a spacing of k+1 bit cells. A good interval is one where the pulse arrives exactly k+1 cycles after the previous pulse. For `pat_sel` 0, 1 and 2, `pre_det` rises after the clock edge that samples the 32nd consecutive good interval.
- R4: For `pat_sel` 3, `pre_det` rises after the edge that samples the 16th consecutive good interval.
- R5: The first pulse after arming only sets the reference and is not counted, so 32 pulses at spacing 1 do not set the flag.
- R6: Once `pre_det` is 1, it stays 1 while `rd_gate` stays 1, whatever `pulse_in` and `pat_sel` do.
- R7: When `rd_gate` is 0 at a clock edge, the flag, run count and interval count are cleared after that edge. A new `zps_done` is then needed before searching resumes.
- R8: A pulse that arrives sooner than the selected spacing clears the run count. That pulse becomes the new reference.
- R9: If no pulse arrives at the selected spacing, the run count is cleared and the next pulse becomes the reference.
- R10: A change of `pat_sel` while tracking clears the run count. The next pulse after the change becomes the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data-synchronous clock, one cycle per bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_gate | input | 1 | Read gate; low aborts and clears the search |
| zps_done | input | 1 | Strobe: zero-phase-start sequence complete |
| pat_sel | input | 2 | Spacing select, value k means k+1 bit cells |
| pulse_in | input | 1 | Sampled read-data pulse for the current bit cell |
| pre_det | output | 1 | Preamble detected, latched high |

## Verification
The bench checks both edges of each run length. The flag must stay low after 32 pulses at spacing 1, because one of them is only the reference, and must rise on the next good pulse. A design that counted the reference pulse, or that used the long target for the 4-cell spacing, would lock one pulse early or sixteen pulses late. Several cases must force a full new run before the flag can rise: a short interval, a missing pulse, and a select change part-way through a run. A design that kept the partial count in any of these cases would lock too early. The bench also sends pulses before the done strobe, a strobe while the gate is low, and disturbance after lock. These catch a design that arms too soon, fails to re-arm after the gate drops, or lets the latched flag fall.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_ARMED,
        S_TRACK,
        S_LOCKED
    } ppd_state_e;
endpackage

// File: rtl/ppd_gap_timer.sv
module ppd_gap_timer #(
    parameter int MAX_SPAN = 4,
    localparam int GAP_W = $clog2(MAX_SPAN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pulse,
    output logic [GAP_W-1:0] gap
);
    // Cells elapsed since the last pulse; saturates at the widest spacing.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (clr) begin
            gap <= '0;
        end else if (pulse) begin
            gap <= GAP_W'(1);
        end else if (gap != '0 && gap < GAP_W'(MAX_SPAN)) begin
            gap <= gap + GAP_W'(1);
        end
    end

    // R9: the interval count never runs past the widest spacing
    a_r9_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        gap <= GAP_W'(MAX_SPAN));
endmodule

// File: rtl/ppd_run_counter.sv
module ppd_run_counter #(
    parameter int RUN_MAX = 32,
    localparam int RUN_W = $clog2(RUN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [RUN_W-1:0] run
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= '0;
        end else if (clr) begin
            run <= '0;
        end else if (inc) begin
            run <= run + RUN_W'(1);
        end
    end

    // R3: the run count stays within the longest target
    a_r3_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run <= RUN_W'(RUN_MAX));
endmodule

// File: rtl/ppd_run_detector.sv
module ppd_run_detector
    import ppd_pkg::*;
#(
    parameter int SEL_W     = 2,
    parameter int RUN_LONG  = 32,
    parameter int RUN_SHORT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_gate,
    input  logic             zps_done,
    input  logic [SEL_W-1:0] pat_sel,
    input  logic             pulse_in,
    output logic             pre_det
);
    localparam int MAX_SPAN = 1 << SEL_W;
    localparam int GAP_W    = $clog2(MAX_SPAN + 1);
    localparam int RUN_W    = $clog2(RUN_LONG + 1);

    ppd_state_e        st, nxt;
    logic [SEL_W-1:0]  sel_q;
    logic [GAP_W-1:0]  gap;
    logic [GAP_W-1:0]  spacing;
    logic [RUN_W-1:0]  run_cnt;
    logic [RUN_W-1:0]  run_tgt;
    logic              sel_chg, interval_ok, overdue;
    logic              run_clr, run_inc;

    assign spacing     = GAP_W'(pat_sel) + GAP_W'(1);
    assign run_tgt     = (pat_sel == {SEL_W{1'b1}}) ? RUN_W'(RUN_SHORT) : RUN_W'(RUN_LONG);
    assign sel_chg     = (pat_sel != sel_q);
    assign interval_ok = (gap == spacing);
    assign overdue     = (gap == spacing);

    ppd_gap_timer #(.MAX_SPAN(MAX_SPAN)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!rd_gate),
        .pulse (pulse_in),
        .gap   (gap)
    );

    ppd_run_counter #(.RUN_MAX(RUN_LONG)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (run_clr),
        .inc   (run_inc),
        .run   (run_cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            sel_q <= '0;
        end else begin
            st    <= nxt;
            sel_q <= pat_sel;
        end
    end

    // Transitions: ARM, REFER, GOOD, SLIP, LOST, LOCK, DROP
    always_comb begin
        nxt     = st;
        run_clr = 1'b0;
        run_inc = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (rd_gate && zps_done) nxt = S_ARMED;             // ARM
            end
            S_ARMED: begin
                if (pulse_in) nxt = S_TRACK;                          // REFER
            end
            S_TRACK: begin
                if (sel_chg) begin                                    // LOST (select)
                    nxt     = S_ARMED;
                    run_clr = 1'b1;
                end else if (pulse_in) begin
                    if (interval_ok) begin                            // GOOD
                        run_inc = 1'b1;
                        if (run_cnt == run_tgt - RUN_W'(1)) nxt = S_LOCKED; // LOCK
                    end else begin                                    // SLIP
                        run_clr = 1'b1;
                    end
                end else if (overdue) begin                           // LOST (gap)
                    nxt     = S_ARMED;
                    run_clr = 1'b1;
                end
            end
            S_LOCKED: begin
                nxt = S_LOCKED;
            end
            default: nxt = S_IDLE;
        endcase
        if (!rd_gate) begin                                           // DROP
            nxt     = S_IDLE;
            run_clr = 1'b1;
            run_inc = 1'b0;
        end
    end

    // Outputs
    always_comb begin
        pre_det = (st == S_LOCKED);
    end

    // R6: latched flag holds while the gate stays high
    a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_det && rd_gate) |=> pre_det);

    // R7: gate low clears flag and both counters on the next edge
    a_r7_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_gate |=> (!pre_det && run_cnt == '0 && gap == '0));

    // R3: the flag rises only from a run one short of its target
    a_r3_lock_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pre_det) |-> ($past(run_cnt) == $past(run_tgt) - RUN_W'(1)));

    // R10: a select change while tracking drops the run
    a_r10_sel_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_TRACK && sel_chg && rd_gate) |=> (run_cnt == '0 && st == S_ARMED));
endmodule

// File: tb/ppd_run_detector_test.sv
module ppd_run_detector_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_gate = 1'b0;
    logic       zps_done = 1'b0;
    logic [1:0] pat_sel = 2'd0;
    logic       pulse_in = 1'b0;
    logic       pre_det;

    typedef struct {
        logic  exp;
        string req;
    } item_t;

    item_t q[$];
    int    errors = 0;
    int    checks = 0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    // Bench model state, built from the requirements
    bit         m_arm, m_ref, m_flag;
    int         m_run, m_gap;
    logic [1:0] m_psel;

    always #4 clk = ~clk;

    ppd_run_detector uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_gate  (rd_gate),
        .zps_done (zps_done),
        .pat_sel  (pat_sel),
        .pulse_in (pulse_in),
        .pre_det  (pre_det)
    );

    task automatic step(input logic g, input logic z, input logic [1:0] s, input logic p);
        int n;
        int tgt;
        item_t it;
        @(negedge clk);
        rd_gate = g; zps_done = z; pat_sel = s; pulse_in = p;
        n   = int'(s) + 1;
        tgt = (s == 2'd3) ? 16 : 32;
        if (!g) begin
            m_arm = 0; m_ref = 0; m_flag = 0; m_run = 0; m_gap = 0;
        end else if (m_flag) begin
        end else if (!m_arm) begin
            if (z) m_arm = 1;
        end else if (!m_ref) begin
            if (p) begin m_ref = 1; m_gap = 1; end
        end else if (s != m_psel) begin
            m_ref = 0; m_run = 0;
        end else if (p) begin
            if (m_gap == n) begin
                m_run++;
                if (m_run == tgt) m_flag = 1;
            end else begin
                m_run = 0;
            end
            m_gap = 1;
        end else if (m_gap == n) begin
            m_ref = 0; m_run = 0;
        end else begin
            m_gap++;
        end
        m_psel = s;
        it.exp = m_flag;
        it.req = cur_req;
        q.push_back(it);
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) step(rd_gate, 1'b0, pat_sel, 1'b0);
    endtask

    // Each pulse is preceded by spacing-1 empty cells
    task automatic train(input int count, input int spacing);
        for (int i = 0; i < count; i++) begin
            for (int j = 1; j < spacing; j++) step(1'b1, 1'b0, pat_sel, 1'b0);
            step(1'b1, 1'b0, pat_sel, 1'b1);
        end
    endtask

    task automatic drop_and_arm(input logic [1:0] s);
        step(1'b0, 1'b0, s, 1'b0);
        step(1'b1, 1'b0, s, 1'b0);
        step(1'b1, 1'b1, s, 1'b0);
    endtask

    // Monitor: compare after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (pre_det !== it.exp) begin
                    errors++;
                    $display("FAIL %s: pre_det=%0b expected %0b at %0t", it.req, pre_det, it.exp, $time);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_arm = 0; m_ref = 0; m_flag = 0; m_run = 0; m_gap = 0; m_psel = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        checks++;
        if (pre_det !== 1'b0) begin
            errors++;
            $display("FAIL R1: pre_det=%0b expected 0", pre_det);
        end

        // R2: pulses before arming, strobe while gate low
        cur_req = "R2";
        train(40, 1);
        step(1'b0, 1'b1, 2'd0, 1'b0);
        step(1'b1, 1'b0, 2'd0, 1'b0);
        train(40, 1);

        // R5 then R3 at spacing 1
        step(1'b1, 1'b1, 2'd0, 1'b0);
        cur_req = "R5";
        train(32, 1);
        cur_req = "R3";
        train(1, 1);

        // R6: disturbance after lock
        cur_req = "R6";
        train(10, 3);
        step(1'b1, 1'b0, 2'd2, 1'b1);
        idle(8);

        // R7: drop, then no re-arm without strobe
        cur_req = "R7";
        step(1'b0, 1'b0, 2'd0, 1'b0);
        step(1'b1, 1'b0, 2'd0, 1'b0);
        train(40, 1);

        // R3 at spacings 2 and 3
        cur_req = "R3";
        drop_and_arm(2'd1);
        train(33, 2);
        drop_and_arm(2'd2);
        train(33, 3);

        // R4 at spacing 4
        cur_req = "R4";
        drop_and_arm(2'd3);
        train(16, 4);
        train(1, 4);

        // R8: short interval restarts
        cur_req = "R8";
        drop_and_arm(2'd1);
        train(20, 2);
        train(1, 1);
        train(31, 2);
        train(1, 2);

        // R9: missing pulse restarts
        cur_req = "R9";
        drop_and_arm(2'd0);
        train(20, 1);
        idle(1);
        train(32, 1);
        train(1, 1);

        // R10: select change restarts
        cur_req = "R10";
        drop_and_arm(2'd1);
        train(20, 2);
        step(1'b1, 1'b0, 2'd0, 1'b1);
        train(31, 1);
        train(1, 1);

        idle(1);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule